// File: doc/BRIEF.md
# Input Gating with Hold Latch

This block stops a chosen group of input pins from toggling the logic behind them. It has one shared, active-low gate rail. While the rail is low, every input chosen by the participation mask is cut off from the core side, and a per-pin hold latch keeps the value that the pin had at the instant the rail fell. Pins outside the mask always reach the core unchanged. When the rail goes high again, the gated inputs follow their pins in the same cycle, with no extra register stage.

The rail is the output of one designated register cell. That cell has two sources. In direct mode it copies a source input on each clock edge. In idle-timer mode it drops the rail after a set number of consecutive quiet edges, and it raises the rail again on the first edge that sees a wake request. The rail value is also driven onto a pin so that it can be observed outside the block. When gating is switched off, that pin carries an ordinary user output and no input is held.

Top module: `input_hold_gate`

## Requirements
- R1: After reset, the rail cell is high (not gating), `railPin` is 1 when `gatingOn` is 1, and `coreIn` equals `pinIn`.
- R2: With `gatingOn`=1 and `railMode`=0 (direct), the rail takes the value of `railSrc` sampled at each rising clock edge, so it changes one edge after `railSrc` changes.
- R3: While `gatingOn`=1 and the rail is low, each `coreIn` bit whose `gateMask` bit is 1 shows the `pinIn` value present at the edge where the rail fell. Later changes on that pin have no effect on it.
- R4: A `coreIn` bit whose `gateMask` bit is 0 always equals its `pinIn` bit, whatever the state of the rail.
- R5: Whenever the rail is high or gating is off, `coreIn` equals `pinIn` in the same cycle. This includes the first cycle after the rail rises.
- R6: With `gatingOn`=1 and `railMode`=1 (idle timer), the rail falls on the IDLE_LIMIT-th consecutive rising edge that samples `railSrc`=0. Any edge that samples `railSrc`=1 sets the rail high and restarts the count.
- R7: With `gatingOn`=0, `railPin` equals `userIo` in the same cycle, every input passes through, and the rail cell is forced high at the next edge.
- R8: With `gatingOn`=1, `railPin` shows the rail cell's value (1 = pass, 0 = gate).

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the rail cell |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | WIDTH | Raw input pins |
| gateMask | input | WIDTH | 1 = pin takes part in gating |
| gatingOn | input | 1 | 1 = gating function in use |
| railMode | input | 1 | Rail source: 0 direct, 1 idle timer |
| railSrc | input | 1 | Direct rail value, or wake request in timer mode |
| userIo | input | 1 | Value for the rail pin when gating is off |
| railPin | output | 1 | Rail value, or `userIo` when gating is off |
| coreIn | output | WIDTH | Gated inputs toward the core logic |

## Verification
Two kinds of internal fault can show at the ports. A wrong rail value or a wrong idle count appears on `railPin` at the first edge after the fault, and it also changes which masked bits of `coreIn` are held. A hold latch that captures at the wrong moment, or that leaks while closed, shows up only while the rail is low and the pins move. For that reason the bench toggles masked pins on every frozen cycle and compares `coreIn` against the value captured at the fall, in each such cycle. Errors in the timer count are pinned to a single edge, because the rail's fall edge is predicted exactly.

// File: rtl/hold_gate_pkg.sv
package hold_gate_pkg;

  // Source that drives the rail cell.
  typedef enum logic {
    SRC_DIRECT = 1'b0,
    SRC_IDLE   = 1'b1
  } railSrcMode_e;

  // Strobes from control toward the datapath.
  typedef struct packed {
    logic freeze;   // 1 = masked inputs are held
  } gateCtl_t;

endpackage

// File: rtl/hold_gate_ctrl.sv
module hold_gate_ctrl
  import hold_gate_pkg::*;
#(
  parameter int IDLE_LIMIT = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     gatingOn,
  input  logic     railMode,
  input  logic     railSrc,
  input  logic     userIo,
  output logic     railPin,
  output gateCtl_t ctl
);

  localparam int CNT_W = (IDLE_LIMIT < 2) ? 1 : $clog2(IDLE_LIMIT);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(IDLE_LIMIT - 1);

  railSrcMode_e modeSel;
  logic         railReg;
  logic [CNT_W-1:0] idleCnt;

  assign modeSel = railSrcMode_e'(railMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      railReg <= 1'b1;
      idleCnt <= '0;
    end else if (!gatingOn) begin
      railReg <= 1'b1;
      idleCnt <= '0;
    end else if (modeSel == SRC_DIRECT) begin
      railReg <= railSrc;
      idleCnt <= '0;
    end else if (railSrc) begin
      railReg <= 1'b1;
      idleCnt <= '0;
    end else if (idleCnt == LAST_CNT) begin
      railReg <= 1'b0;
    end else begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign railPin    = gatingOn ? railReg : userIo;
  assign ctl.freeze = gatingOn & ~railReg;

endmodule

// File: rtl/hold_gate_path.sv
module hold_gate_path
  import hold_gate_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] gateMask,
  input  gateCtl_t         ctl,
  output logic [WIDTH-1:0] coreIn
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic holdQ;

    // Transparent while not frozen; keeps the value at the freeze instant.
    always_latch begin
      if (!ctl.freeze) holdQ <= pinIn[i];
    end

    assign coreIn[i] = (gateMask[i] & ctl.freeze) ? holdQ : pinIn[i];
  end

endmodule

// File: rtl/input_hold_gate.sv
module input_hold_gate
  import hold_gate_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int IDLE_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] gateMask,
  input  logic             gatingOn,
  input  logic             railMode,
  input  logic             railSrc,
  input  logic             userIo,
  output logic             railPin,
  output logic [WIDTH-1:0] coreIn
);

  gateCtl_t ctl;

  hold_gate_ctrl #(.IDLE_LIMIT(IDLE_LIMIT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .gatingOn (gatingOn),
    .railMode (railMode),
    .railSrc  (railSrc),
    .userIo   (userIo),
    .railPin  (railPin),
    .ctl      (ctl)
  );

  hold_gate_path #(.WIDTH(WIDTH)) path_i (
    .pinIn    (pinIn),
    .gateMask (gateMask),
    .ctl      (ctl),
    .coreIn   (coreIn)
  );

endmodule

// File: rtl/input_hold_gate_chk.sv
module input_hold_gate_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] pinIn,
  input logic [WIDTH-1:0] gateMask,
  input logic             gatingOn,
  input logic             railMode,
  input logic             railSrc,
  input logic             userIo,
  input logic             railPin,
  input logic [WIDTH-1:0] coreIn
);

  assert_direct_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (gatingOn && !railMode) |=> (!gatingOn || railPin == $past(railSrc)));

  assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (gatingOn && !railPin && $past(gatingOn && !railPin) && $stable(gateMask))
      |-> $stable(coreIn & gateMask));

  assert_unmasked_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coreIn & ~gateMask) == (pinIn & ~gateMask));

  assert_open_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!gatingOn || railPin) |-> coreIn == pinIn);

  assert_wake_raise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (gatingOn && railSrc) |=> (railPin || !gatingOn));

  assert_user_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
    !gatingOn |-> railPin == userIo);

endmodule

bind input_hold_gate input_hold_gate_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/input_hold_gate_tb_top.sv
`timescale 1ns/100ps
module input_hold_gate_tb_top;

  localparam int W     = 8;
  localparam int LIMIT = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] gateMask = '0;
  logic         gatingOn = 1'b0;
  logic         railMode = 1'b0;
  logic         railSrc = 1'b1;
  logic         userIo = 1'b0;
  logic         railPin;
  logic [W-1:0] coreIn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit           mRail = 1;
  int           mQuiet = 0;
  logic [W-1:0] mHeld = '0;

  always #2.5 clk = ~clk;

  input_hold_gate #(.WIDTH(W), .IDLE_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .gateMask(gateMask),
    .gatingOn(gatingOn), .railMode(railMode), .railSrc(railSrc),
    .userIo(userIo), .railPin(railPin), .coreIn(coreIn)
  );

  function automatic bit effLow();
    return gatingOn && !mRail;
  endfunction

  task automatic compare(input string tag);
    logic [W-1:0] expCore;
    logic expPin;
    if (!effLow()) mHeld = pinIn;
    expCore = effLow() ? ((mHeld & gateMask) | (pinIn & ~gateMask)) : pinIn;
    expPin  = gatingOn ? mRail : userIo;
    checks++;
    if (coreIn !== expCore) begin
      errors++;
      $display("FAIL %s coreIn actual=%b expected=%b", tag, coreIn, expCore);
    end
    checks++;
    if (railPin !== expPin) begin
      errors++;
      $display("FAIL %s railPin actual=%b expected=%b", tag, railPin, expPin);
    end
  endtask

  // model update at the rising edge, using inputs held across it
  task automatic modelEdge();
    if (!rstN) begin
      mRail = 1; mQuiet = 0;
    end else if (!gatingOn) begin
      mRail = 1; mQuiet = 0;
    end else if (!railMode) begin
      mRail = railSrc; mQuiet = 0;
    end else if (railSrc) begin
      mRail = 1; mQuiet = 0;
    end else begin
      mQuiet++;
      if (mQuiet >= LIMIT) mRail = 0;
    end
    if (!effLow()) mHeld = pinIn;
  endtask

  // one cycle: drive at negedge, check before the edge, then advance model
  task automatic step(input string tag, input logic [W-1:0] p, input logic [W-1:0] m,
                      input logic on, input logic mode, input logic src, input logic uio);
    @(negedge clk);
    pinIn = p; gateMask = m; gatingOn = on; railMode = mode; railSrc = src; userIo = uio;
    #1;
    compare(tag);
    @(posedge clk);
    modelEdge();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step("R1", W'($urandom), 8'hF0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk); rstN = 1'b1;
    step("R1", 8'h5A, 8'hF0, 1'b1, 1'b0, 1'b1, 1'b0);

    // R5 open rail, varying pins
    for (int i = 0; i < 6; i++) step("R5", W'($urandom), 8'hF0, 1'b1, 1'b0, 1'b1, 1'b0);

    // R2 direct mode: drop rail, then R3/R4 hold vs pass
    step("R2", 8'hA5, 8'hF0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step("R3", W'($urandom), 8'hF0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step("R4", W'($urandom), 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step("R3", W'($urandom), 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2/R5 raise and pass in the very next cycle
    step("R2", 8'h3C, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step("R5", W'($urandom), 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);

    // R6 idle timer: interrupted count, then full count and wake
    for (int i = 0; i < LIMIT - 1; i++) step("R6", W'($urandom), 8'hCC, 1'b1, 1'b1, 1'b0, 1'b0);
    step("R6", W'($urandom), 8'hCC, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < LIMIT + 4; i++) step("R6", W'($urandom), 8'hCC, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step("R6", W'($urandom), 8'hCC, 1'b1, 1'b1, 1'b1, 1'b0);

    // R8 rail visible on the pin across a direct toggle pattern
    for (int i = 0; i < 6; i++) step("R8", W'($urandom), 8'hAA, 1'b1, 1'b0, i[0], 1'b1);

    // R7 gating off while frozen: pin shows userIo, all pass
    step("R7", 8'h11, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R7", 8'h22, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step("R7", W'($urandom), 8'hFF, 1'b0, 1'b0, 1'b0, i[0]);
    step("R7", 8'h77, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1);
    step("R5", 8'h88, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule